// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers transfer-completion notices from a DMA engine and folds them into one interrupt line shared by every completion code. Each notice brings the transfer's 32-bit option word. A 6-bit completion code inside that word picks one of 64 flags in a pending register. The flag is recorded only when the word's completion-interrupt-enable bit is set. Software sees the pending and enable registers as two 32-bit halves each. It can poll the pending flags, mask them with the enable register, and acknowledge them with write-one-to-clear writes.

The interrupt output is an edge-style pulse, not a level. After a pulse the block is disarmed. New completions are still recorded, but no further pulse goes out until software writes the re-evaluate register. That write re-arms the block, and if any flag is then both pending and enabled, a new pulse follows. A completion that lands while software is servicing earlier ones is therefore never lost.

Top module: `cmpl_irq_agg`

## Requirements
- R1: While `evt_valid` is high with option bit 20 set, the completion code in option bits 17:12 sets its pending flag at the next clock edge.
- R2: A completion whose option bit 20 is 0 leaves both pending halves unchanged.
- R3: Pending flags are recorded whatever the enable register holds. With a flag's enable bit clear, no interrupt pulse results from it.
- R4: Codes 0–31 map to bit `code` of the low halves (pending address 0, enable address 4). Codes 32–63 map to bit `code-32` of the high halves (pending address 1, enable address 5).
- R5: Writing to enable-set addresses 6 (low) and 7 (high) sets each enable bit written as 1. Bits written as 0 keep their value.
- R6: Writing to pending-clear addresses 2 (low) and 3 (high) clears each pending bit written as 1. All other pending bits are kept.
- R7: Writing to enable-clear addresses 8 (low) and 9 (high) clears each enable bit written as 1. All other enable bits are kept.
- R8: When the block is armed and any flag is both pending and enabled, `irq` goes high for exactly one clock cycle. It rises one cycle after the cycle in which the flag first becomes visible in the registers, and the block then disarms.
- R9: While the block is disarmed, new pending-and-enabled flags produce no pulse.
- R10: A write to address 10 with data bit 0 set re-arms the block, so a pulse follows if a pending-and-enabled flag remains. With bit 0 clear, the write does nothing. If nothing is pending and enabled, the block stays armed and fires on the next qualifying completion.
- R11: When a completion and a pending-clear write target the same bit in the same cycle, the bit ends up set.
- R12: Synchronous reset clears all pending and enable bits, drives `irq` low and leaves the block armed.
- R13: `rd_data` returns the register at `rd_addr` one clock later. Write-only addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Completion notice strobe |
| evt_opt | input | 32 | Option word of the completed transfer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Shared completion interrupt pulse |

## Verification
The assertions assume that `evt_valid` and `wr_en` stay low while reset is held, so that the first cycle after reset starts with no pending update in flight. The bench keeps every strobe idle through reset and then drives one completion or one write per cycle. The exception is the single collision case, which deliberately drives a completion and a pending-clear write together. The bench also never writes the re-evaluate register in the cycle the block fires, so the one-cycle pulse width is exercised only under the orderings software is expected to produce.

// File: rtl/cia_pkg.sv
package cia_pkg;
  localparam int OPT_W     = 32;
  localparam int CODE_W    = 6;
  localparam int CODE_LSB  = 12;
  localparam int IEN_BIT   = 20;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 4;

  typedef struct packed {
    logic              ien;
    logic [CODE_W-1:0] code;
  } evt_fields_t;

  function automatic evt_fields_t unpack_opt(input logic [OPT_W-1:0] opt);
    evt_fields_t f;
    f.ien  = opt[IEN_BIT];
    f.code = opt[CODE_LSB +: CODE_W];
    return f;
  endfunction
endpackage

// File: rtl/cia_evt_decode.sv
module cia_evt_decode #(
  parameter int CODE_W    = 6,
  parameter int NUM_CODES = 1 << CODE_W
) (
  input  logic                 evt_valid,
  input  logic                 evt_ien,
  input  logic [CODE_W-1:0]    evt_code,
  output logic [NUM_CODES-1:0] set_vec
);
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign set_vec[i] = evt_valid & evt_ien & (evt_code == CODE_W'(i));
  end
endmodule

// File: rtl/cia_flag_bank.sv
module cia_flag_bank #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_vec) | set_vec;
  end

  // set has priority over a simultaneous clear
  p_set_lands_r11: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // no flag rises without a set request
  p_only_set_raises_r2: assert property (@(posedge clk) disable iff (rst)
    (set_vec == '0) |=> ((flags & ~$past(flags)) == '0));

  // cleared bits without a set fall
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/cia_irq_gen.sv
module cia_irq_gen #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] en,
  input  logic         rearm,
  output logic         irq
);
  logic armed_q;
  logic any_live;
  logic fire;

  assign any_live = |(pend & en);
  assign fire     = armed_q & any_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      irq     <= 1'b0;
    end else begin
      irq <= fire;
      if (rearm)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

  // a pulse needs a pending-and-enabled flag in the cycle before
  p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(any_live));

  // disarmed block cannot pulse next cycle
  p_quiet_disarmed_r9: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !irq);

  // after a pulse without re-arm the block is disarmed
  p_disarm_after_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(rearm)) |-> !armed_q);
endmodule

// File: rtl/cmpl_irq_agg.sv
module cmpl_irq_agg
  import cia_pkg::*;
#(
  parameter int NUM_CODES = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [OPT_W-1:0]  evt_opt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  localparam int HALVES     = NUM_CODES / REG_W;
  localparam int PEND_BASE  = 0;
  localparam int PCLR_BASE  = HALVES;
  localparam int EN_BASE    = 2 * HALVES;
  localparam int ESET_BASE  = 3 * HALVES;
  localparam int ECLR_BASE  = 4 * HALVES;
  localparam int REEVAL_ADR = 5 * HALVES;

  evt_fields_t          evt_f;
  logic [NUM_CODES-1:0] evt_set;
  logic [NUM_CODES-1:0] pend_clr;
  logic [NUM_CODES-1:0] en_set;
  logic [NUM_CODES-1:0] en_clr;
  logic [NUM_CODES-1:0] pend_q;
  logic [NUM_CODES-1:0] en_q;
  logic                 rearm;
  logic [REG_W-1:0]     rd_mux;

  assign evt_f = unpack_opt(evt_opt);

  logic unused_opt_bits;
  assign unused_opt_bits = ^{evt_opt[OPT_W-1:IEN_BIT+1], evt_opt[IEN_BIT-1:CODE_LSB+CODE_W],
                             evt_opt[CODE_LSB-1:0]};

  cia_evt_decode #(.CODE_W(CODE_W), .NUM_CODES(NUM_CODES)) u_dec (
    .evt_valid (evt_valid),
    .evt_ien   (evt_f.ien),
    .evt_code  (evt_f.code),
    .set_vec   (evt_set)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign pend_clr[h*REG_W +: REG_W] =
      (wr_en && wr_addr == ADDR_W'(PCLR_BASE + h)) ? wr_data : '0;
    assign en_set[h*REG_W +: REG_W] =
      (wr_en && wr_addr == ADDR_W'(ESET_BASE + h)) ? wr_data : '0;
    assign en_clr[h*REG_W +: REG_W] =
      (wr_en && wr_addr == ADDR_W'(ECLR_BASE + h)) ? wr_data : '0;
  end

  assign rearm = wr_en && (wr_addr == ADDR_W'(REEVAL_ADR)) && wr_data[0];

  cia_flag_bank #(.N(NUM_CODES)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_vec (evt_set),
    .clr_vec (pend_clr),
    .flags   (pend_q)
  );

  cia_flag_bank #(.N(NUM_CODES)) u_en (
    .clk     (clk),
    .rst     (rst),
    .set_vec (en_set),
    .clr_vec (en_clr),
    .flags   (en_q)
  );

  cia_irq_gen #(.N(NUM_CODES)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend_q),
    .en    (en_q),
    .rearm (rearm),
    .irq   (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (rd_addr == ADDR_W'(PEND_BASE + h)) rd_mux = pend_q[h*REG_W +: REG_W];
      if (rd_addr == ADDR_W'(EN_BASE + h))   rd_mux = en_q[h*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // qualifying completion lands in its pending bit
  p_event_recorded_r1: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_f.ien) |=> pend_q[$past(evt_f.code)]);

  // read data follows the addressed pending half one cycle later
  p_read_latency_r13: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(PEND_BASE)) |=> (rd_data == $past(pend_q[REG_W-1:0])));
endmodule

// File: tb/tb_cmpl_irq_agg.sv
module tb_cmpl_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [31:0] evt_opt = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int errs = 0;
  int checks = 0;
  int irq_cnt = 0;
  int wide_cnt = 0;
  logic prev_irq = 1'b0;
  bit done = 0;

  localparam logic [3:0] A_PLO = 0, A_PHI = 1, A_CLO = 2, A_CHI = 3,
                         A_ELO = 4, A_EHI = 5, A_SLO = 6, A_SHI = 7,
                         A_XLO = 8, A_XHI = 9, A_RE = 10;

  always #2 clk = ~clk;

  cmpl_irq_agg dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_opt(evt_opt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (irq) irq_cnt <= irq_cnt + 1;
      if (irq && prev_irq) wide_cnt <= wide_cnt + 1;
      prev_irq <= irq;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] opt_of(input int code, input bit ien);
    logic [31:0] o;
    o = 32'h0;
    o[17:12] = 6'(code);
    o[20] = ien;
    o[3:0] = 4'h5;
    return o;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic evt(input int code, input bit ien);
    @(negedge clk);
    evt_valid = 1'b1; evt_opt = opt_of(code, ien);
    @(negedge clk);
    evt_valid = 1'b0; evt_opt = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), d);
      check("R12 reset register", d, 32'h0);
    end
    check("R12 no irq after reset", 32'(irq_cnt), 32'd0);
  endtask

  task automatic t_poll();
    logic [31:0] d;
    evt(5, 1'b1); idle(4);
    rd(A_PLO, d); check("R1 pending bit 5 set", d, 32'h20);
    check("R3 no pulse with enable clear", 32'(irq_cnt), 32'd0);
    evt(7, 1'b0); idle(2);
    rd(A_PLO, d); check("R2 ien=0 records nothing", d, 32'h20);
    rd(A_PHI, d); check("R2 high half untouched", d, 32'h0);
  endtask

  task automatic t_high();
    logic [31:0] d;
    evt(40, 1'b1); idle(2);
    rd(A_PHI, d); check("R4 code 40 -> high bit 8", d, 32'h100);
    rd(A_PLO, d); check("R4 low half unchanged", d, 32'h20);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_SLO, 32'h200); idle(4);
    rd(A_ELO, d); check("R5 enable set bit 9", d, 32'h200);
    check("R3 pending 5 without enable no pulse", 32'(irq_cnt), 32'd0);
    wr(A_SLO, 32'h20); idle(4);
    rd(A_ELO, d); check("R5 zeros keep other enables", d, 32'h220);
    check("R8 first pulse", 32'(irq_cnt), 32'd1);
  endtask

  task automatic t_hold_rearm();
    logic [31:0] d;
    evt(9, 1'b1); idle(4);
    check("R9 no pulse while disarmed", 32'(irq_cnt), 32'd1);
    rd(A_PLO, d); check("R9 event still recorded", d, 32'h220);
    wr(A_RE, 32'h0); idle(4);
    check("R10 bit0 clear does nothing", 32'(irq_cnt), 32'd1);
    wr(A_RE, 32'h1); idle(4);
    check("R10 re-evaluate pulses", 32'(irq_cnt), 32'd2);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CLO, 32'h20); idle(1);
    rd(A_PLO, d); check("R6 clear only bit 5", d, 32'h200);
    wr(A_CLO, 32'h200); idle(1);
    rd(A_PLO, d); check("R6 clear bit 9", d, 32'h0);
    wr(A_RE, 32'h1); idle(4);
    check("R10 re-arm with nothing live no pulse", 32'(irq_cnt), 32'd2);
    evt(9, 1'b1); idle(4);
    check("R10 armed block fires on next event", 32'(irq_cnt), 32'd3);
  endtask

  task automatic t_enclr_high();
    logic [31:0] d;
    wr(A_XLO, 32'h200); idle(1);
    rd(A_ELO, d); check("R7 enable clear bit 9 only", d, 32'h20);
    wr(A_SHI, 32'h100); idle(4);
    rd(A_EHI, d); check("R4 high enable bit 8", d, 32'h100);
    check("R9 high enable no pulse while disarmed", 32'(irq_cnt), 32'd3);
    wr(A_RE, 32'h1); idle(4);
    check("R4 high code pulses after re-arm", 32'(irq_cnt), 32'd4);
    wr(A_XHI, 32'h100); idle(1);
    rd(A_EHI, d); check("R7 high enable cleared", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    evt_valid = 1'b1; evt_opt = opt_of(12, 1'b1);
    wr_en = 1'b1; wr_addr = A_CLO; wr_data = 32'h1200;
    @(negedge clk);
    evt_valid = 1'b0; evt_opt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd(A_PLO, d); check("R11 set wins, bit 9 cleared", d, 32'h1000);
    check("R8 every pulse one cycle wide", 32'(wide_cnt), 32'd0);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    t_reset();
    t_poll();
    t_high();
    t_enable();
    t_hold_rearm();
    t_clear();
    t_enclr_high();
    t_collide();
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule